// File: doc/BRIEF.md
# Record/Playback Phrase Sequencer

This block steers a 13-bit address counter through a segmented storage array while audio is recorded or played back. It takes single-cycle decoded commands and a per-sample tick. It tells an abstract memory port which page is active through the current address and a set of strobes, and it reports activity through four status flags. The address splits into a block field in bits 12..11, a sector field in bits 10..4 and a page field in bits 3..0. A block has 80 sectors and a sector has 16 pages. Each page lasts `PAGE_TICKS` sample ticks and the pre-record erase lasts `ERASE_TICKS` ticks.

A recording always starts on a sector boundary. It begins with a one-sector erase and then writes page by page up to the programmed stop page. When a stop command ends a recording, the current page is finished. A dummy fill then runs to the last page of the following sector. A playback starts at the exact start page, and a stop command ends it at once. A pause command toggles the suspend state. The address counter holds its value after an operation ends, so it can be read back.

Commands arrive as a one-cycle `cmd_valid` pulse and are never back-pressured. A command that does not apply in the current state has no effect. There is no streaming data path; all pins are plain control and status.

Top module: `phrase_seq`

## Requirements
- R1: After page 15 the counter moves to page 0 of the next sector. After sector 0x4F it moves to sector 0 of the next block, so the address after 0x04FF is 0x0800.
- R2: `cmd_op` encodes 0 no-op, 1 record, 2 play, 3 stop, 4 pause, 5 set start address, 6 set stop address. After reset the start address is 0x0000, the stop address is 0x1CFF, and every flag and the counter read zero. Programmed addresses are reused by later operations until they are rewritten.
- R3: A set-start or set-stop command whose address has a sector field (bits 10..4) of 0x50 or more is ignored, and the previous value is kept.
- R4: Play loads the full start address and pulses `page_stb` at the start of each page. It ends after the page equal to the stop address, so MON is high for pages × `PAGE_TICKS` cycles. The counter then holds that stop address.
- R5: Record loads the start address with bits 3..0 cleared and pulses `erase_stb` once. For `ERASE_TICKS` cycles MON is high and RPM is low. It then writes pages with `mem_wr` high, through the stop address.
- R6: A stop during recording drops RPM in the next cycle while MON and `mem_wr` stay high. The current page is completed. Dummy pages then run through page 15 of the following sector, after which MON falls.
- R7: During record or play, each pause command toggles VPM. While VPM is high no tick is consumed, no page strobe occurs and the address holds. Pause has no effect when idle.
- R8: A stop during a paused recording clears VPM and RPM in the next cycle. It then performs the trailing page and the dummy fill of R6.
- R9: A stop during playback, whether paused or not, drops MON, RPM and VPM in the next cycle. The address holds its last value.
- R10: FULL rises in the cycle MON falls, only when the operation ended at the last address 0x1CFF. It is cleared when the next record or play starts.
- R11: Record and play commands received while MON is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per audio sample |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | 13 | Address for the set-start and set-stop commands |
| cur_addr | output | 13 | Address counter, also the memory page address |
| mon | output | 1 | High while any operation phase is active |
| rpm | output | 1 | High only during audio-active record or play |
| vpm | output | 1 | High while suspended by pause |
| full | output | 1 | Operation ended at the last memory address |
| mem_wr | output | 1 | High during record, trailing and dummy phases |
| page_stb | output | 1 | Pulse when a new page becomes active |
| sector_stb | output | 1 | Pulse when the new page is page 0 of a sector |
| erase_stb | output | 1 | Pulse when the sector erase begins |

## Verification
The hardest state to reach from the ports is a stop that arrives while a recording is paused on the last page of a sector. From that state the dummy fill must cover the whole following sector. The stimulus watches `page_stb` and `cur_addr` for that exact page and issues the pause and then the stop in the cycles after it. The counts and addresses of the dummy pages that follow are then checked. Reaching the end of memory uses a short playback that starts in the final sector, which shows FULL rising together with the fall of MON.

// File: rtl/phrase_seq_pkg.sv
package phrase_seq_pkg;
  localparam int PAGE_W  = 4;
  localparam int SECT_W  = 7;
  localparam int BLK_W   = 2;
  localparam int ADDR_W  = BLK_W + SECT_W + PAGE_W;
  localparam int SECTORS = 80;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t LAST_ADDR = {{BLK_W{1'b1}}, SECT_W'(SECTORS - 1), {PAGE_W{1'b1}}};

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_REC       = 3'd1,
    OP_PLAY      = 3'd2,
    OP_STOP      = 3'd3,
    OP_PAUSE     = 3'd4,
    OP_SET_START = 3'd5,
    OP_SET_STOP  = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE, ST_REC, ST_PLAY, ST_TRAIL, ST_DUMMY
  } st_e;

  function automatic logic sector_ok(input addr_t a);
    return a[PAGE_W +: SECT_W] < SECT_W'(SECTORS);
  endfunction

  function automatic addr_t step_page(input addr_t a);
    logic [PAGE_W-1:0] pg;
    logic [SECT_W-1:0] sc;
    logic [BLK_W-1:0]  bk;
    {bk, sc, pg} = a;
    if (pg != {PAGE_W{1'b1}}) begin
      pg = pg + 1'b1;
    end else begin
      pg = '0;
      if (sc == SECT_W'(SECTORS - 1)) begin
        sc = '0;
        bk = bk + 1'b1;
      end else begin
        sc = sc + 1'b1;
      end
    end
    return {bk, sc, pg};
  endfunction

  // last page of the sector that follows the one holding a
  function automatic addr_t sector_end_after(input addr_t a);
    addr_t n;
    if (a[ADDR_W-1:PAGE_W] == LAST_ADDR[ADDR_W-1:PAGE_W]) return LAST_ADDR;
    n = step_page({a[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}});
    return {n[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
  endfunction
endpackage

// File: rtl/seq_addr_regs.sv
module seq_addr_regs
  import phrase_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  addr_t       cmd_addr,
  output addr_t       start_addr,
  output addr_t       stop_addr
);
  logic addr_good;
  assign addr_good = sector_ok(cmd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      stop_addr  <= LAST_ADDR;
    end else if (cmd_valid && addr_good) begin
      if (cmd_op == OP_SET_START) start_addr <= cmd_addr;
      if (cmd_op == OP_SET_STOP)  stop_addr  <= cmd_addr;
    end
  end

  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sector_ok(start_addr) && sector_ok(stop_addr)); // R3
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !addr_good) |=> ($stable(start_addr) && $stable(stop_addr))); // R3
endmodule

// File: rtl/seq_addr_ctr.sv
module seq_addr_ctr
  import phrase_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_val,
  input  logic  step,
  output addr_t addr,
  output addr_t addr_nxt,
  output logic  at_last
);
  assign addr_nxt = step_page(addr);
  assign at_last  = (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr_nxt;
  end

  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr[PAGE_W +: SECT_W] < SECT_W'(SECTORS)); // R1
  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> !at_last); // R10
endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] tcnt;

  assign done = en && tick && (tcnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) tcnt <= '0;
    else if (en && tick) tcnt <= done ? '0 : tcnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < limit); // R4
endmodule

// File: rtl/phrase_seq.sv
module phrase_seq
  import phrase_seq_pkg::*;
#(
  parameter int PAGE_TICKS  = 64,
  parameter int ERASE_TICKS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [12:0] cmd_addr,
  output logic [12:0] cur_addr,
  output logic        mon,
  output logic        rpm,
  output logic        vpm,
  output logic        full,
  output logic        mem_wr,
  output logic        page_stb,
  output logic        sector_stb,
  output logic        erase_stb
);
  localparam int TMAX = (PAGE_TICKS > ERASE_TICKS) ? PAGE_TICKS : ERASE_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  st_e   st, st_n;
  logic  paused, paused_n, full_n, pg_n, er_n, sec_n;
  addr_t dend, dend_n;
  addr_t start_addr, stop_addr, addr_nxt, ld_val, new_addr;
  logic  ld, step, tclr, t_en, t_done, at_last;
  logic [TW-1:0] limit;
  op_e   op;

  assign op = cmd_valid ? op_e'(cmd_op) : OP_NOP;

  seq_addr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .start_addr(start_addr), .stop_addr(stop_addr)
  );

  seq_addr_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .step(step),
    .addr(cur_addr), .addr_nxt(addr_nxt), .at_last(at_last)
  );

  assign limit = (st == ST_ERASE) ? TW'(ERASE_TICKS) : TW'(PAGE_TICKS);
  assign t_en  = (st == ST_ERASE) || (st == ST_TRAIL) || (st == ST_DUMMY) ||
                 (((st == ST_REC) || (st == ST_PLAY)) && !paused);

  seq_tick_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tclr), .en(t_en), .tick(tick),
    .limit(limit), .done(t_done)
  );

  always_comb begin
    st_n     = st;
    paused_n = paused;
    full_n   = full;
    dend_n   = dend;
    pg_n     = 1'b0;
    er_n     = 1'b0;
    ld       = 1'b0;
    ld_val   = start_addr;
    step     = 1'b0;
    tclr     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (op == OP_REC) begin
          st_n   = ST_ERASE;
          ld     = 1'b1;
          ld_val = {start_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
          tclr   = 1'b1;
          er_n   = 1'b1;
          full_n = 1'b0;
        end else if (op == OP_PLAY) begin
          st_n   = ST_PLAY;
          ld     = 1'b1;
          tclr   = 1'b1;
          pg_n   = 1'b1;
          full_n = 1'b0;
        end
      end
      ST_ERASE: begin
        if (op == OP_STOP) begin
          st_n = ST_IDLE;
          tclr = 1'b1;
        end else if (t_done) begin
          st_n = ST_REC;
          pg_n = 1'b1;
        end
      end
      ST_REC, ST_PLAY: begin
        if (op == OP_PAUSE) paused_n = !paused;
        if (t_done) begin
          if ((cur_addr == stop_addr) || at_last) begin
            st_n     = ST_IDLE;
            paused_n = 1'b0;
            full_n   = at_last;
          end else begin
            step = 1'b1;
            pg_n = 1'b1;
          end
        end
        if ((op == OP_STOP) && (st_n != ST_IDLE)) begin
          paused_n = 1'b0;
          st_n     = (st == ST_REC) ? ST_TRAIL : ST_IDLE;
          tclr     = (st == ST_PLAY);
        end
      end
      ST_TRAIL: begin
        if (t_done) begin
          if (at_last) begin
            st_n   = ST_IDLE;
            full_n = 1'b1;
          end else begin
            st_n   = ST_DUMMY;
            dend_n = sector_end_after(cur_addr);
            step   = 1'b1;
            pg_n   = 1'b1;
          end
        end
      end
      ST_DUMMY: begin
        if (t_done) begin
          if ((cur_addr == dend) || at_last) begin
            st_n   = ST_IDLE;
            full_n = at_last;
          end else begin
            step = 1'b1;
            pg_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign new_addr = ld ? ld_val : (step ? addr_nxt : cur_addr);
  assign sec_n    = pg_n && (new_addr[PAGE_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      paused     <= 1'b0;
      full       <= 1'b0;
      dend       <= '0;
      page_stb   <= 1'b0;
      sector_stb <= 1'b0;
      erase_stb  <= 1'b0;
    end else begin
      st         <= st_n;
      paused     <= paused_n;
      full       <= full_n;
      dend       <= dend_n;
      page_stb   <= pg_n;
      sector_stb <= sec_n;
      erase_stb  <= er_n;
    end
  end

  assign mon    = (st != ST_IDLE);
  assign rpm    = (st == ST_REC) || (st == ST_PLAY);
  assign vpm    = paused;
  assign mem_wr = (st == ST_REC) || (st == ST_TRAIL) || (st == ST_DUMMY);

  AST_RPM_NEEDS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    (rpm || vpm) |-> mon); // R6
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (vpm && $past(vpm)) |-> ($stable(cur_addr) && !page_stb)); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon && $past(!mon)) |-> $stable(cur_addr)); // R4
  AST_FULL_WITH_MON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($fell(mon) && (cur_addr == LAST_ADDR))); // R10
  AST_ERASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    erase_stb |-> (mon && !rpm && (cur_addr[PAGE_W-1:0] == '0))); // R5
  AST_TRAIL_KEEPS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rpm) && mem_wr) |-> mon); // R6
  AST_SECTOR_STB_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sector_stb |-> (page_stb && (cur_addr[PAGE_W-1:0] == '0))); // R1
endmodule

// File: tb/test_phrase_seq.sv
module test_phrase_seq;
  localparam int PT = 3;
  localparam int ET = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [12:0] cmd_addr = '0;
  logic [12:0] cur_addr;
  logic        mon, rpm, vpm, full, mem_wr, page_stb, sector_stb, erase_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int npg, nwr, ner, nsec;
  logic [12:0] first_pg, last_pg, prev_800;

  always #5 clk = ~clk;

  phrase_seq #(.PAGE_TICKS(PT), .ERASE_TICKS(ET)) i_phrase_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cur_addr(cur_addr), .mon(mon),
    .rpm(rpm), .vpm(vpm), .full(full), .mem_wr(mem_wr), .page_stb(page_stb),
    .sector_stb(sector_stb), .erase_stb(erase_stb)
  );

  always @(negedge clk) begin
    if (page_stb) begin
      if (npg == 0) first_pg = cur_addr;
      if (cur_addr == 13'h0800) prev_800 = last_pg;
      last_pg = cur_addr;
      npg++;
      if (mem_wr) nwr++;
    end
    if (erase_stb) ner++;
    if (sector_stb) nsec++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int lin(input logic [12:0] a);
    return int'(a[12:11]) * 1280 + int'(a[10:4]) * 16 + int'(a[3:0]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    npg = 0; nwr = 0; ner = 0; nsec = 0;
    first_pg = '0; last_pg = '0; prev_800 = '0;
  endtask

  task automatic send(input logic [2:0] op, input logic [12:0] a);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (mon && c < 100000) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic wait_page(input logic [12:0] a, output bit found);
    found = 1'b0;
    for (int i = 0; i < 20000 && !found; i++) begin
      @(negedge clk);
      if (page_stb && cur_addr == a) found = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset mon", int'(mon), 0);
    chk("R2 reset rpm", int'(rpm), 0);
    chk("R2 reset vpm", int'(vpm), 0);
    chk("R2 reset full", int'(full), 0);
    chk("R2 reset addr", int'(cur_addr), 0);
  endtask

  task automatic t_default_start();
    int c;
    send(3'd6, 13'h0002);
    clear_mon();
    send(3'd2, 13'h0);
    wait_idle(c);
    chk("R2 default start first page", int'(first_pg), 0);
    chk("R4 page count", npg, 3);
    chk("R4 mon high cycles", c, 3 * PT);
    chk("R4 frozen addr", int'(cur_addr), 2);
    chk("R4 play no write", nwr, 0);
  endtask

  task automatic t_play_span();
    int c;
    send(3'd5, 13'h0123);
    send(3'd6, 13'h0135);
    clear_mon();
    send(3'd2, 13'h0);
    wait_idle(c);
    chk("R4 play first page", int'(first_pg), 'h123);
    chk("R4 play pages", npg, lin(13'h0135) - lin(13'h0123) + 1);
    chk("R4 play cycles", c, PT * (lin(13'h0135) - lin(13'h0123) + 1));
    chk("R4 play end addr", int'(cur_addr), 'h135);
    repeat (5) @(negedge clk);
    chk("R4 addr holds after end", int'(cur_addr), 'h135);
  endtask

  task automatic t_wrap();
    int c;
    send(3'd5, 13'h04F8);
    send(3'd6, 13'h0802);
    clear_mon();
    send(3'd2, 13'h0);
    wait_idle(c);
    chk("R1 page before 0x0800", int'(prev_800), 'h04FF);
    chk("R1 pages across block", npg, 11);
    chk("R1 sector starts", nsec, 1);
    chk("R1 end addr", int'(cur_addr), 'h0802);
  endtask

  task automatic t_full();
    int c;
    do_reset();
    send(3'd5, 13'h1CF0);
    clear_mon();
    send(3'd2, 13'h0);
    chk("R10 full low while running", int'(full), 0);
    wait_idle(c);
    chk("R10 full with mon fall", int'(full), 1);
    chk("R10 pages to end", npg, 16);
    chk("R10 end addr", int'(cur_addr), 'h1CFF);
    send(3'd5, 13'h0000);
    send(3'd6, 13'h0001);
    send(3'd2, 13'h0);
    chk("R10 full cleared on start", int'(full), 0);
    wait_idle(c);
    chk("R10 full stays low at stop addr", int'(full), 0);
  endtask

  task automatic t_record();
    int c;
    send(3'd5, 13'h0125);
    send(3'd6, 13'h0133);
    clear_mon();
    send(3'd1, 13'h0);
    c = 0;
    while (mon && !rpm && c < 100) begin
      c++;
      @(negedge clk);
    end
    chk("R5 erase cycles", c, ET);
    chk("R5 aligned start addr", int'(cur_addr), 'h120);
    wait_idle(c);
    chk("R5 erase strobes", ner, 1);
    chk("R5 first page", int'(first_pg), 'h120);
    chk("R5 pages", npg, lin(13'h0133) - lin(13'h0120) + 1);
    chk("R5 written pages", nwr, npg);
    chk("R5 end addr", int'(cur_addr), 'h133);
  endtask

  task automatic t_rec_stop();
    int c;
    bit f;
    send(3'd5, 13'h0200);
    send(3'd6, 13'h1CFF);
    send(3'd1, 13'h0);
    wait_page(13'h0205, f);
    chk("R6 reached page", int'(f), 1);
    send(3'd3, 13'h0);
    chk("R6 rpm drops", int'(rpm), 0);
    chk("R6 mon stays", int'(mon), 1);
    chk("R6 write stays", int'(mem_wr), 1);
    clear_mon();
    wait_idle(c);
    chk("R6 dummy pages", npg, 26);
    chk("R6 dummy writes", nwr, 26);
    chk("R6 dummy last page", int'(last_pg), 'h021F);
    chk("R6 end addr", int'(cur_addr), 'h021F);
  endtask

  task automatic t_rec_pause();
    int c;
    bit f;
    send(3'd5, 13'h0300);
    send(3'd1, 13'h0);
    wait_page(13'h0303, f);
    send(3'd4, 13'h0);
    chk("R7 vpm set", int'(vpm), 1);
    chk("R7 rpm kept", int'(rpm), 1);
    clear_mon();
    repeat (12) @(negedge clk);
    chk("R7 no pages while paused", npg, 0);
    chk("R7 addr held", int'(cur_addr), 'h0303);
    send(3'd4, 13'h0);
    chk("R7 vpm cleared", int'(vpm), 0);
    wait_page(13'h030F, f);
    chk("R7 resumed", int'(f), 1);
    send(3'd4, 13'h0);
    chk("R8 paused again", int'(vpm), 1);
    send(3'd3, 13'h0);
    chk("R8 vpm cleared by stop", int'(vpm), 0);
    chk("R8 rpm drops", int'(rpm), 0);
    chk("R8 mon stays", int'(mon), 1);
    clear_mon();
    wait_idle(c);
    chk("R8 dummy pages", npg, 16);
    chk("R8 dummy last", int'(last_pg), 'h031F);
    chk("R8 end addr", int'(cur_addr), 'h031F);
  endtask

  task automatic t_play_stop();
    bit f;
    int c;
    send(3'd5, 13'h0040);
    send(3'd6, 13'h0050);
    send(3'd2, 13'h0);
    wait_page(13'h0045, f);
    send(3'd4, 13'h0);
    chk("R7 play vpm", int'(vpm), 1);
    repeat (9) @(negedge clk);
    chk("R7 play addr held", int'(cur_addr), 'h0045);
    send(3'd3, 13'h0);
    chk("R9 paused stop mon", int'(mon), 0);
    chk("R9 paused stop vpm", int'(vpm), 0);
    chk("R9 paused stop rpm", int'(rpm), 0);
    chk("R9 paused stop addr", int'(cur_addr), 'h0045);
    chk("R9 no full", int'(full), 0);
    send(3'd4, 13'h0);
    chk("R7 idle pause ignored vpm", int'(vpm), 0);
    chk("R7 idle pause ignored mon", int'(mon), 0);
    send(3'd2, 13'h0);
    wait_page(13'h0042, f);
    send(3'd3, 13'h0);
    chk("R9 running stop mon", int'(mon), 0);
    chk("R9 running stop addr", int'(cur_addr), 'h0042);
    wait_idle(c);
  endtask

  task automatic t_reject();
    int c;
    send(3'd5, 13'h0100);
    send(3'd6, 13'h0102);
    send(3'd5, 13'h0500);
    send(3'd6, 13'h07F3);
    clear_mon();
    send(3'd2, 13'h0);
    wait_idle(c);
    chk("R3 start kept", int'(first_pg), 'h0100);
    chk("R3 stop kept", int'(cur_addr), 'h0102);
    chk("R3 pages", npg, 3);
    clear_mon();
    send(3'd2, 13'h0);
    wait_idle(c);
    chk("R2 reuse start", int'(first_pg), 'h0100);
    chk("R2 reuse stop", int'(cur_addr), 'h0102);
  endtask

  task automatic t_busy();
    int c;
    bit f;
    send(3'd5, 13'h0010);
    send(3'd6, 13'h0014);
    clear_mon();
    send(3'd2, 13'h0);
    wait_page(13'h0011, f);
    send(3'd1, 13'h0);
    send(3'd2, 13'h0);
    wait_idle(c);
    chk("R11 no erase", ner, 0);
    chk("R11 no write", nwr, 0);
    chk("R11 first page", int'(first_pg), 'h0010);
    chk("R11 pages", npg, 5);
    chk("R11 end addr", int'(cur_addr), 'h0014);
  endtask

  initial begin
    clear_mon();
    t_reset();
    t_default_start();
    t_play_span();
    t_wrap();
    t_full();
    t_record();
    t_rec_stop();
    t_rec_pause();
    t_play_stop();
    t_reject();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule